// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one memory-operand request into the data-memory address that the load/store path will use. A request carries a mode code, a base register value, an index register value, a 16-bit displacement field and an operand-size code. The block sign-extends the displacement, applies the chosen addressing rule and presents the address with a one-cycle valid pulse.

Two modes change the base register. Post-increment uses the base as the address and returns base plus the operand size for write-back. Pre-decrement subtracts the operand size first, then uses that value as both the address and the write-back value. Pointer-chase mode first issues a memory read at the base address and waits for the read data. The data that comes back becomes the final address. While that read is outstanding the block is busy and accepts no new request.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (base+offset) yields base plus the sign-extended 16-bit displacement, with wraparound at the address width.
- R2: Mode 1 (register indirect) yields the base value unchanged.
- R3: Mode 2 (indexed) yields base plus index.
- R4: Mode 3 (absolute) yields the sign-extended displacement.
- R5: Mode 4 (scaled) yields displacement plus base plus index shifted left by the size code. Size code 0, 1 and 2 mean 1, 2 and 4 bytes, and code 3 also means 4 bytes.
- R6: Mode 6 (post-increment) yields the base as the address and write-back data equal to base plus the operand size.
- R7: Mode 7 (pre-decrement) yields base minus the operand size as both the address and the write-back data.
- R8: Mode 5 (pointer chase) raises the read request with read address equal to base one cycle after start. Busy stays high and the read address stays fixed until a read-valid arrives. One cycle after that, the read data is the address with valid high, and the request and busy are low.
- R9: For every mode other than 5, the address valid output is high exactly the one cycle after an accepted start.
- R10: The write-back enable pulses only for modes 6 and 7, in the same cycle as address valid.
- R11: A start while busy, and a read-valid while idle, have no effect on any output.
- R12: After reset, address valid, write-back enable, read request and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode | input | 3 | Addressing mode code |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| disp | input | 16 | Displacement field, sign-extended inside |
| size_code | input | 2 | Operand size as a left-shift amount |
| mem_rd_data | input | AW | Pointer data returned by memory |
| mem_rd_valid | input | 1 | Pointer data is valid |
| addr | output | AW | Effective address |
| addr_valid | output | 1 | Address valid pulse |
| wb_data | output | AW | Updated base value |
| wb_en | output | 1 | Base write-back enable pulse |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | AW | Pointer read address |
| busy | output | 1 | Pointer read outstanding |

## Verification
The bench uses the default 32-bit address width. At that width, random base and index values regularly make the sums wrap past the top of the address space. Negative displacements are mixed with large bases so that sign extension and borrow are checked together. Directed cases put the maximum shift and size code 3 against all-ones operands. Pointer-chase runs use random wait lengths, with stray starts and idle read-valids injected to check that they are ignored.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [15:0]   disp,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] mem_rd_data,
  input  logic          mem_rd_valid,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  output logic          busy
);
  localparam logic [2:0] M_DISP = 3'd0, M_RIND = 3'd1, M_IDX = 3'd2, M_ABS = 3'd3,
                         M_SCL = 3'd4, M_PTR = 3'd5, M_INC = 3'd6, M_DEC = 3'd7;

  logic          waiting;
  logic [1:0]    shamt;
  logic [AW-1:0] dext, step, ea_c, upd_c;
  logic          is_auto;

  assign shamt   = (size_code == 2'd3) ? 2'd2 : size_code;
  assign dext    = {{(AW-16){disp[15]}}, disp};
  assign step    = AW'(1) << shamt;
  assign is_auto = (mode == M_INC) || (mode == M_DEC);
  assign busy    = waiting;

  always_comb begin
    upd_c = (mode == M_DEC) ? base - step : base + step;
    case (mode)
      M_DISP:  ea_c = base + dext;
      M_RIND:  ea_c = base;
      M_IDX:   ea_c = base + index;
      M_ABS:   ea_c = dext;
      M_SCL:   ea_c = dext + base + (index << shamt);
      M_DEC:   ea_c = base - step;
      default: ea_c = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr        <= '0;
      addr_valid  <= 1'b0;
      wb_data     <= '0;
      wb_en       <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      waiting     <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      wb_en      <= 1'b0;
      if (waiting) begin
        if (mem_rd_valid) begin
          addr       <= mem_rd_data;
          addr_valid <= 1'b1;
          mem_rd_req <= 1'b0;
          waiting    <= 1'b0;
        end
      end else if (start) begin
        if (mode == M_PTR) begin
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= base;
          waiting     <= 1'b1;
        end else begin
          addr       <= ea_c;
          addr_valid <= 1'b1;
          wb_en      <= is_auto;
          if (is_auto) wb_data <= upd_c;
        end
      end
    end
  end
endmodule

module ea_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic          mem_rd_valid,
  input logic [AW-1:0] mem_rd_addr,
  input logic          addr_valid,
  input logic          wb_en,
  input logic          mem_rd_req,
  input logic          busy
);
  AST_WB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> addr_valid); // R10
  AST_SINGLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode != 3'd5) |=> addr_valid); // R9
  AST_PTR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 3'd5) |=> (mem_rd_req && busy)); // R8
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy); // R8
  AST_RADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd_valid) |=> (busy && $stable(mem_rd_addr))); // R8
  AST_NO_VALID_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd_valid) |=> (!addr_valid && !wb_en)); // R11
  AST_PTR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rd_valid) |=> (addr_valid && !busy && !wb_en)); // R8
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_rd_valid = 1'b0;
  logic [2:0] mode = '0;
  logic [AW-1:0] base = '0, index = '0, mem_rd_data = '0;
  logic [15:0] disp = '0;
  logic [1:0] size_code = '0;
  logic [AW-1:0] addr, wb_data, mem_rd_addr;
  logic addr_valid, wb_en, mem_rd_req, busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ea_gen #(.AW(AW)) u0 (.*);

  function automatic logic [AW-1:0] sx(input logic [15:0] d);
    return {{(AW-16){d[15]}}, d};
  endfunction
  function automatic logic [AW-1:0] sz(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [AW-1:0] exp_addr(input logic [2:0] m, input logic [AW-1:0] b, i,
                                             input logic [15:0] d, input logic [1:0] s);
    case (m)
      3'd0: return b + sx(d);
      3'd1: return b;
      3'd2: return b + i;
      3'd3: return sx(d);
      3'd4: return sx(d) + b + i * sz(s);
      3'd7: return b - sz(s);
      default: return b;
    endcase
  endfunction
  function automatic string rq(input logic [2:0] m);
    case (m)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd6: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(input string r, input logic [AW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic single(input logic [2:0] m, input logic [AW-1:0] b, i,
                        input logic [15:0] d, input logic [1:0] s);
    @(negedge clk);
    mode = m; base = b; index = i; disp = d; size_code = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", AW'(addr_valid), 1);
    chk(rq(m), addr, exp_addr(m, b, i, d, s));
    chk("R10", AW'(wb_en), AW'(m == 3'd6 || m == 3'd7));
    if (m == 3'd6) chk("R6", wb_data, b + sz(s));
    if (m == 3'd7) chk("R7", wb_data, b - sz(s));
    @(negedge clk);
    chk("R9", AW'(addr_valid), 0);
    chk("R10", AW'(wb_en), 0);
  endtask

  task automatic chase(input logic [AW-1:0] b, ptr, input int waitc);
    @(negedge clk);
    mode = 3'd5; base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", AW'({mem_rd_req, busy}), 3);
    chk("R8", mem_rd_addr, b);
    for (int k = 0; k < waitc; k++) begin
      mode = 3'd6; base = ~b; start = (k == 0);
      @(negedge clk);
      start = 1'b0;
      chk("R11", AW'({addr_valid, wb_en, busy}), 1);
      chk("R8", mem_rd_addr, b);
    end
    mem_rd_data = ptr; mem_rd_valid = 1'b1;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk("R8", AW'({addr_valid, mem_rd_req, busy}), 4);
    chk("R8", addr, ptr);
    @(negedge clk);
    chk("R8", AW'(addr_valid), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R12", AW'({addr_valid, wb_en, mem_rd_req, busy}), 0);
    rst_n = 1'b1;
    single(3'd0, 32'h0000_0010, 0, 16'hFFF0, 0);
    single(3'd0, 32'hFFFF_FFFF, 0, 16'h0001, 0);
    single(3'd1, 32'hDEAD_BEEF, 32'h1, 16'h7FFF, 2);
    single(3'd2, 32'hFFFF_FFF0, 32'h20, 0, 0);
    single(3'd3, 32'h1234, 0, 16'h8000, 0);
    single(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 2'd3);
    single(3'd4, 32'h100, 32'h3, 16'h0004, 2'd1);
    single(3'd6, 32'hFFFF_FFFE, 0, 0, 2);
    single(3'd7, 32'h0000_0001, 0, 0, 1);
    chase(32'h4000, 32'hCAFE_0000, 0);
    chase(32'h8000, 32'h0000_1234, 5);
    @(negedge clk);
    mem_rd_valid = 1'b1; mem_rd_data = 32'h5555;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk("R11", AW'({addr_valid, busy, mem_rd_req}), 0);
    chk("R11", addr, 32'h0000_1234);
    for (int n = 0; n < 400; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      if (m == 3'd5) chase($urandom, $urandom, $urandom_range(0, 4));
      else single(m, $urandom, $urandom, 16'($urandom), 2'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule